// File: doc/BRIEF.md
# Binary64 to binary32 narrowing converter

The block turns one IEEE-754 double-precision word into the nearest single-precision word, rounding to nearest with ties going to the even result. Each input word is sorted into one of four classes by magnitude: in range, NaN, too large, and too small. An in-range value is rebiased and rounded. A NaN keeps its sign and its upper payload bits and always comes out quiet. A value that is too large becomes infinity. A value that is too small is denormalised with a sticky bit and becomes a single-precision subnormal or zero.

The interface is a valid flag with a 64-bit word in and a valid flag with a 32-bit word out. The parameter `OUT_REG` selects between a purely combinational path and a single output register. With the default of 1, a result appears one clock after its input.

Top module: `dnarrow_f64_f32`

## Requirements
- R1: The result sign (bit 31) equals the input sign (bit 63) for every class of input, zeros and NaNs included.
- R2: An input with biased exponent from 897 to 1150 gives biased exponent (input exponent − 896) and the upper 23 input mantissa bits when the 29 dropped bits (input bits 28:0) are below half, i.e. below bit 28 alone.
- R3: When the dropped bits exceed half, the result is one unit in the last place larger than the truncated value.
- R4: When the dropped bits equal exactly half (only bit 28 set), the result is rounded up if the truncated mantissa LSB is 1 and left unchanged if it is 0.
- R5: A rounding carry ripples into the exponent field. At the top of the range it produces infinity (0x7F800000 with sign).
- R6: A non-NaN input with biased exponent 1151 or above, input infinity included, gives infinity with the input sign.
- R7: An input with exponent 2047 and a nonzero mantissa gives exponent 0xFF with bit 22 set and bits 21:0 equal to input bits 50:29. The input quiet bit 51 is not copied, so signalling and quiet NaNs alike come out quiet.
- R8: An input with biased exponent 1 to 896 is shifted right by (897 − exponent) with the implicit one included. Any bits lost in that shift set a sticky bit. The 29 low bits are then rounded as in R3 and R4, so the result may be a subnormal or the smallest normal (0x00800000).
- R9: When the denormalising shift exceeds 52, the result is zero with the input sign. This covers input zeros and binary64 subnormals.
- R10: With `OUT_REG`=1, `out_valid_o` equals `in_valid_i` of the previous cycle and is 0 during and right after reset. The data for a valid output is the converted word from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input word is valid |
| in_data_i | input | 64 | Binary64 operand |
| out_valid_o | output | 1 | Result is valid |
| out_data_o | output | 32 | Binary32 result |

## Verification
Rounding and exponent change can fall on the same word in two places. The first is where a mantissa carry from rounding lifts the largest finite single into infinity. The second is where a subnormal rounds up into the smallest normal. Directed words sit exactly on these seams, for example the largest finite value plus one exact half unit and the largest subnormal plus nearly a unit. Each result is judged bit for bit against hand-derived constants. Random words, weighted toward the exponents around both seams, are then compared against a bench model that rounds by a single unified shift.

// File: rtl/dnarrow_pkg.sv
package dnarrow_pkg;
  localparam int unsigned SRC_W     = 64;
  localparam int unsigned SRC_EXP_W = 11;
  localparam int unsigned DST_W     = 32;
  localparam int unsigned DST_EXP_W = 8;

  localparam int unsigned MAG_W     = SRC_W - 1;
  localparam int unsigned SRC_MAN_W = SRC_W - 1 - SRC_EXP_W;
  localparam int unsigned DST_MAN_W = DST_W - 1 - DST_EXP_W;
  localparam int unsigned DROP_W    = SRC_MAN_W - DST_MAN_W;
  localparam int unsigned SIG_W     = SRC_MAN_W + 1;
  localparam int unsigned DMAG_W    = DST_W - 1;
  localparam int unsigned SRC_BIAS  = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int unsigned DST_BIAS  = (1 << (DST_EXP_W - 1)) - 1;
  localparam int unsigned BIAS_DIFF = SRC_BIAS - DST_BIAS;
  localparam int unsigned DST_EXP_MAX = (1 << DST_EXP_W) - 1;

  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_NAN  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_TINY = 2'd3
  } cls_e;
endpackage

// File: rtl/dnarrow_classify.sv
module dnarrow_classify
  import dnarrow_pkg::*;
(
  input  logic [MAG_W-1:0] mag_i,
  output cls_e             cls_o
);
  localparam logic [MAG_W-1:0] UF_TH  = MAG_W'(BIAS_DIFF + 1) << SRC_MAN_W;
  localparam logic [MAG_W-1:0] OF_TH  = MAG_W'(BIAS_DIFF + DST_EXP_MAX) << SRC_MAN_W;
  localparam logic [MAG_W-1:0] INF_PT = MAG_W'((1 << SRC_EXP_W) - 1) << SRC_MAN_W;

  logic [MAG_W-1:0] d_uf, d_of;
  logic             in_rng;

  // wrapping differences: one unsigned compare tests UF_TH <= mag < OF_TH
  assign d_uf   = mag_i - UF_TH;
  assign d_of   = mag_i - OF_TH;
  assign in_rng = d_uf < d_of;

  always_comb begin
    if (in_rng)               cls_o = CLS_NORM;
    else if (mag_i > INF_PT)  cls_o = CLS_NAN;
    else if (mag_i >= OF_TH)  cls_o = CLS_INF;
    else                      cls_o = CLS_TINY;
  end
endmodule

// File: rtl/dnarrow_denorm.sv
module dnarrow_denorm
  import dnarrow_pkg::*;
(
  input  logic [MAG_W-1:0] mag_i,
  output logic [SIG_W-1:0] den_o,
  output logic             zero_o
);
  logic [SRC_EXP_W-1:0] exp_f;
  logic [SRC_EXP_W-1:0] shamt;
  logic [SIG_W-1:0]     sig, lost_mask;
  logic                 sticky;

  assign exp_f     = mag_i[MAG_W-1 -: SRC_EXP_W];
  assign shamt     = SRC_EXP_W'(BIAS_DIFF + 1) - exp_f;
  assign zero_o    = shamt > SRC_EXP_W'(SRC_MAN_W);
  assign sig       = {1'b1, mag_i[SRC_MAN_W-1:0]};
  assign lost_mask = ~({SIG_W{1'b1}} << shamt);
  assign sticky    = |(sig & lost_mask);
  assign den_o     = (sig >> shamt) | {{(SIG_W-1){1'b0}}, sticky};
endmodule

// File: rtl/dnarrow_rne.sv
module dnarrow_rne
  import dnarrow_pkg::*;
(
  input  logic [DMAG_W-1:0] trunc_i,
  input  logic [DROP_W-1:0] rbits_i,
  output logic [DMAG_W-1:0] mag_o
);
  localparam logic [DROP_W-1:0] HALF = DROP_W'(1) << (DROP_W - 1);

  logic up;
  assign up    = (rbits_i > HALF) || ((rbits_i == HALF) && trunc_i[0]);
  assign mag_o = trunc_i + DMAG_W'(up);
endmodule

// File: rtl/dnarrow_f64_f32.sv
module dnarrow_f64_f32
  import dnarrow_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [SRC_W-1:0]  in_data_i,
  output logic              out_valid_o,
  output logic [DST_W-1:0]  out_data_o
);
  localparam logic [DMAG_W-1:0] REBIAS  = DMAG_W'(BIAS_DIFF) << DST_MAN_W;
  localparam logic [DMAG_W-1:0] INF_MAG = DMAG_W'(DST_EXP_MAX) << DST_MAN_W;

  logic [MAG_W-1:0]  mag;
  logic              sgn;
  cls_e              cls;
  logic [SIG_W-1:0]  den;
  logic              den_zero;
  logic [DMAG_W-1:0] pre, rounded, mag_res;
  logic [DROP_W-1:0] rbits;
  logic [DST_W-1:0]  result;

  assign mag = in_data_i[MAG_W-1:0];
  assign sgn = in_data_i[SRC_W-1];

  dnarrow_classify u_cls (.mag_i(mag), .cls_o(cls));

  dnarrow_denorm u_den (.mag_i(mag), .den_o(den), .zero_o(den_zero));

  always_comb begin
    if (cls == CLS_NORM) begin
      pre   = mag[DROP_W +: DMAG_W] - REBIAS;
      rbits = mag[DROP_W-1:0];
    end else begin
      pre   = DMAG_W'(den[SIG_W-1:DROP_W]);
      rbits = den[DROP_W-1:0];
    end
  end

  dnarrow_rne u_rne (.trunc_i(pre), .rbits_i(rbits), .mag_o(rounded));

  always_comb begin
    unique case (cls)
      CLS_NORM: mag_res = rounded;
      CLS_NAN:  mag_res = INF_MAG | (DMAG_W'(1) << (DST_MAN_W - 1))
                          | DMAG_W'(mag[SRC_MAN_W-2 -: DST_MAN_W-1]);
      CLS_INF:  mag_res = INF_MAG;
      default:  mag_res = den_zero ? '0 : rounded;
    endcase
  end

  assign result = {sgn, mag_res};

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          out_valid_o <= 1'b0;
          out_data_o  <= '0;
        end else begin
          out_valid_o <= in_valid_i;
          if (in_valid_i) out_data_o <= result;
        end
      end
    end else begin : g_comb
      assign out_valid_o = in_valid_i;
      assign out_data_o  = result;
    end
  endgenerate
endmodule

// File: rtl/dnarrow_chk.sv
module dnarrow_chk
  import dnarrow_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [SRC_W-1:0] in_data_i,
  input logic             out_valid_o,
  input logic [DST_W-1:0] out_data_o
);
  localparam logic [MAG_W-1:0] INF_SRC = MAG_W'((1 << SRC_EXP_W) - 1) << SRC_MAN_W;
  localparam logic [MAG_W-1:0] TINY_Z  = MAG_W'(1) << SRC_MAN_W;
  localparam logic [DMAG_W-1:0] INF_DST = DMAG_W'(DST_EXP_MAX) << DST_MAN_W;

  logic [SRC_W-1:0] src;

  generate
    if (OUT_REG) begin : g_reg
      logic [SRC_W-1:0] src_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) src_q <= '0;
        else         src_q <= in_data_i;
      end
      assign src = src_q;

      p_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);
      p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);
    end else begin : g_comb
      assign src = in_data_i;
    end
  endgenerate

  p_sign_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o[DST_W-1] == src[SRC_W-1]);

  p_nan_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && src[MAG_W-1:0] > INF_SRC)
      |-> (out_data_o[DMAG_W-1 -: DST_EXP_W] == '1) && out_data_o[DST_MAN_W-1]);

  p_inf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && src[MAG_W-1:0] == INF_SRC) |-> out_data_o[DMAG_W-1:0] == INF_DST);

  p_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && src[MAG_W-1:0] < TINY_Z) |-> out_data_o[DMAG_W-1:0] == '0);

  p_no_nan_from_num_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && src[MAG_W-1:0] <= INF_SRC) |-> out_data_o[DMAG_W-1:0] <= INF_DST);
endmodule

bind dnarrow_f64_f32 dnarrow_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
  .out_valid_o(out_valid_o), .out_data_o(out_data_o));

// File: tb/dnarrow_f64_f32_bench.sv
module dnarrow_f64_f32_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dnarrow_f64_f32 u_dnarrow_f64_f32 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data));

  // model: one right shift by 29 plus extra denormalising distance, then RNE
  function automatic logic [31:0] ref_narrow(input logic [63:0] x);
    logic        s;
    int          ex, e, sh;
    logic [63:0] sig, q, rem, half;
    longint      res;
    s  = x[63];
    ex = int'(x[62:52]);
    if (ex == 2047) begin
      if (x[51:0] == '0) return {s, 31'h7F800000};
      return {s, 8'hFF, 1'b1, x[50:29]};
    end
    if (ex == 0) return {s, 31'h0};
    sig = {11'b0, 1'b1, x[51:0]};
    e   = ex - 1023;
    sh  = 29 + ((e < -126) ? (-126 - e) : 0);
    if (sh >= 60) return {s, 31'h0};
    q    = sig >> sh;
    rem  = sig & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && q[0])) q = q + 64'd1;
    res = ((e >= -126) ? longint'(e + 126) : 64'sd0) * 64'sd8388608 + longint'(q);
    if (res >= 64'sh7F800000) return {s, 31'h7F800000};
    return {s, res[30:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [63:0] x, input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    check(req, out_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3 + 2);
    check("R10 reset", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle", {31'b0, out_valid}, 32'd0);

    apply("R2 one",            64'h3FF0000000000000, 32'h3F800000);
    apply("R2 below half",     64'h3FF000000FFFFFFF, 32'h3F800000);
    apply("R3 above half",     64'h3FF0000010000001, 32'h3F800001);
    apply("R4 tie even",       64'h3FF0000010000000, 32'h3F800000);
    apply("R4 tie odd",        64'h3FF0000030000000, 32'h3F800002);
    apply("R1 neg tie odd",    64'hBFF0000030000000, 32'hBF800002);
    apply("R5 max finite",     64'h47EFFFFFE0000000, 32'h7F7FFFFF);
    apply("R5 carry to inf",   64'h47EFFFFFF0000000, 32'h7F800000);
    apply("R5 carry to exp",   64'h3FFFFFFFF0000000, 32'h40000000);
    apply("R2 min normal",     64'h3810000000000000, 32'h00800000);
    apply("R8 sub to normal",  64'h380FFFFFFFFFFFFF, 32'h00800000);
    apply("R8 min subnormal",  64'h36A0000000000000, 32'h00000001);
    apply("R8 half tie zero",  64'h3690000000000000, 32'h00000000);
    apply("R8 sticky up",      64'h3690000000000001, 32'h00000001);
    apply("R8 neg tie",        64'hB690000000000000, 32'h80000000);
    apply("R9 zero",           64'h0000000000000000, 32'h00000000);
    apply("R9 neg zero",       64'h8000000000000000, 32'h80000000);
    apply("R9 f64 subnormal",  64'h800FFFFFFFFFFFFF, 32'h80000000);
    apply("R9 deep tiny",      64'h3000000000000000, 32'h00000000);
    apply("R6 inf",            64'h7FF0000000000000, 32'h7F800000);
    apply("R6 neg inf",        64'hFFF0000000000000, 32'hFF800000);
    apply("R6 overflow",       64'h47F0000000000000, 32'h7F800000);
    apply("R7 qnan",           64'h7FF8000000000000, 32'h7FC00000);
    apply("R7 snan low",       64'h7FF0000000000001, 32'h7FC00000);
    apply("R7 snan payload",   64'h7FF4000020000000, 32'h7FE00001);
    apply("R7 neg qnan",       64'hFFF8000000000000, 32'hFFC00000);

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 drop valid", {31'b0, out_valid}, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] x;
      logic [10:0] ex;
      x = {$urandom(), $urandom()};
      case (i % 4)
        0: ex = x[62:52];
        1: ex = 11'd860 + 11'($urandom_range(0, 50));
        2: ex = 11'd1130 + 11'($urandom_range(0, 30));
        default: ex = 11'd897 + 11'($urandom_range(0, 253));
      endcase
      x[62:52] = ex;
      if (i % 16 == 5) x[28:0] = 29'h10000000;
      apply("R8 random", x, ref_narrow(x));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule